// File: doc/BRIEF.md
# Set-Associative Read Cache with Not-Most-Recently-Used Eviction

This block is a read-only cache placed between a requester and a slower backing memory. The requester presents a byte address, an access size and a read strobe. The address is split into three fields: a block offset in the low bits, a set index above it, and a tag in the remaining high bits. All ways of the selected set are compared in parallel. A hit returns the requested bytes one cycle after acceptance. A miss fetches the whole block through a request/response memory port, installs it in one way and then answers the requester.

Geometry comes from three parameters: sets, ways and block bytes. Their product is the data capacity; valid and tag bits are not part of that capacity. With one way the cache is direct-mapped. With one set the index field disappears and the cache is fully associative. A fill goes to an empty way when the set has one. Otherwise it evicts the lowest-numbered way that is not the set's most recently used way.

Top module: `nmru_read_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0; the first read of any address is a miss.
- R2: With the default geometry (8-byte blocks, 4 sets, 2 ways, 16-bit address), address bits [2:0] are the offset, bits [4:3] pick the set and bits [15:5] are the tag; addresses that differ only in the tag compete for the same set.
- R3: A hit produces `resp_valid`=1 with `resp_hit`=1 in the cycle after acceptance and issues no memory request. `resp_data` holds the bytes starting at the offset, little-endian (lowest address in bits [7:0]), with unused upper bytes zero.
- R4: A miss raises `mem_req_valid` with `mem_req_addr` equal to the request address with its offset bits cleared. Both stay unchanged until `mem_resp_valid` is seen.
- R5: In the cycle after `mem_resp_valid`, the line has been written and the cache answers with `resp_hit`=0, `resp_err`=0 and the requested bytes taken from the returned block; a later read of the same block hits.
- R6: On a miss, an invalid way in the selected set is filled before any valid line is evicted.
- R7: When every way of the set is valid, the victim is the lowest-numbered way that is not the set's most recently used way; hits and fills both update that pointer.
- R8: Only one miss is in flight at a time: `req_ready` is 0 while a refill is outstanding.
- R9: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal. An illegal size, or an address not aligned to its size, answers the next cycle with `resp_err`=1, `resp_hit`=0 and `resp_data`=0, and starts no memory access.
- R10: Sets are independent: fills into one set leave the lines of the other sets resident.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read strobe; accepted when `req_ready` is 1 |
| req_addr | input | ADDR_W | Byte address of the read |
| req_size | input | 2 | Access size code (0/1/2 = 1/2/4 bytes) |
| req_ready | output | 1 | Cache can accept a read |
| resp_valid | output | 1 | Response valid for one cycle |
| resp_data | output | 32 | Returned bytes, little-endian, zero-extended |
| resp_hit | output | 1 | Response came from a resident line |
| resp_err | output | 1 | Request was misaligned or had an illegal size |
| mem_req_valid | output | 1 | Block fetch requested |
| mem_req_addr | output | ADDR_W | Block-aligned fetch address |
| mem_resp_valid | input | 1 | Backing memory returns the block |
| mem_resp_data | input | BLK_BYTES*8 | Whole block, byte 0 in the low bits |

## Verification
Two things happen in the same cycle on a refill: the line is written and the requester receives its response. The bench runs a delayed memory model and compares the bytes of that response against values computed from the address. It then reads the same block again and expects a hit with no memory traffic. It also alternates conflicting tags in a single set while touching the resident line in between. An eviction of the wrong way appears as an unexpected fetch count and an unexpected hit flag.

// File: rtl/nmru_read_cache.sv
module nmru_read_cache #(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 8,
  parameter int WAYS      = 2,
  parameter int SETS      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  output logic                   req_ready,
  output logic                   resp_valid,
  output logic [31:0]            resp_data,
  output logic                   resp_hit,
  output logic                   resp_err,
  output logic                   mem_req_valid,
  output logic [ADDR_W-1:0]      mem_req_addr,
  input  logic                   mem_resp_valid,
  input  logic [BLK_BYTES*8-1:0] mem_resp_data
);
  localparam int OFF_W    = $clog2(BLK_BYTES);
  localparam int SET_BITS = $clog2(SETS);
  localparam int IDX_W    = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int TAG_W    = ADDR_W - OFF_W - SET_BITS;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int BLK_W    = BLK_BYTES * 8;

  logic [WAYS-1:0]  vld   [SETS];
  logic [TAG_W-1:0] tags  [SETS][WAYS];
  logic [BLK_W-1:0] lines [SETS][WAYS];
  logic [WAY_W-1:0] mru   [SETS];

  logic              filling;
  logic [ADDR_W-1:0] pend_addr;
  logic [1:0]        pend_size;

  wire [ADDR_W-1:0] a_addr = filling ? pend_addr : req_addr;
  wire [1:0]        a_size = filling ? pend_size : req_size;
  wire [TAG_W-1:0]  a_tag  = a_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0]  a_off  = a_addr[OFF_W-1:0];
  logic [IDX_W-1:0] a_idx;

  generate
    if (SET_BITS > 0) begin : g_idx
      assign a_idx = a_addr[OFF_W +: IDX_W];
    end else begin : g_noidx
      assign a_idx = '0;
    end
  endgenerate

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;
  logic             have_free;
  logic             misal;

  always_comb begin
    hit_way   = '0;
    victim    = '0;
    have_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hit_vec[w] = vld[a_idx][w] && (tags[a_idx][w] == a_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!vld[a_idx][w]) begin
        victim    = WAY_W'(w);
        have_free = 1'b1;
      end
    end
    if (!have_free)
      for (int w = WAYS - 1; w >= 0; w--)
        if (WAY_W'(w) != mru[a_idx]) victim = WAY_W'(w);
  end

  always_comb begin
    case (req_size)
      2'd0:    misal = 1'b0;
      2'd1:    misal = req_addr[0];
      2'd2:    misal = |req_addr[1:0];
      default: misal = 1'b1;
    endcase
  end

  function automatic logic [31:0] pick(input logic [BLK_W-1:0] blk,
                                       input logic [OFF_W-1:0] off,
                                       input logic [1:0] sz);
    logic [BLK_W+31:0] sh;
    sh = {32'b0, blk} >> {off, 3'b000};
    case (sz)
      2'd0:    return {24'b0, sh[7:0]};
      2'd1:    return {16'b0, sh[15:0]};
      default: return sh[31:0];
    endcase
  endfunction

  assign req_ready     = !filling;
  assign mem_req_valid = filling;
  assign mem_req_addr  = {pend_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  wire accept = req_valid && !filling;
  wire fill   = filling && mem_resp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        mru[s] <= '0;
      end
      filling    <= 1'b0;
      pend_addr  <= '0;
      pend_size  <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_err   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        if (misal) begin
          resp_valid <= 1'b1;
          resp_err   <= 1'b1;
          resp_hit   <= 1'b0;
          resp_data  <= '0;
        end else if (|hit_vec) begin
          resp_valid   <= 1'b1;
          resp_err     <= 1'b0;
          resp_hit     <= 1'b1;
          resp_data    <= pick(lines[a_idx][hit_way], a_off, a_size);
          mru[a_idx]   <= hit_way;
        end else begin
          filling   <= 1'b1;
          pend_addr <= req_addr;
          pend_size <= req_size;
        end
      end else if (fill) begin
        vld[a_idx][victim] <= 1'b1;
        mru[a_idx]         <= victim;
        filling            <= 1'b0;
        resp_valid         <= 1'b1;
        resp_err           <= 1'b0;
        resp_hit           <= 1'b0;
        resp_data          <= pick(mem_resp_data, a_off, a_size);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tags[a_idx][victim]  <= a_tag;
      lines[a_idx][victim] <= mem_resp_data;
    end
  end

  // R3
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid || mem_req_valid);

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr));

  // R5
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_resp_valid |=> resp_valid && !resp_hit && !resp_err && req_ready);

  // R8
  miss_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(req_valid) && !req_ready);

  // R9
  err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_err |-> !resp_hit && resp_data == 32'd0);
endmodule

// File: tb/nmru_read_cache_bench.sv
module nmru_read_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, resp_valid, resp_hit, resp_err, mem_req_valid;
  logic [31:0] resp_data;
  logic [15:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [63:0] mem_resp_data = '0;

  int total = 0;
  int bad = 0;
  int fetches = 0;
  logic [15:0] last_fetch = '0;
  logic busy_bad = 1'b0;

  always #2 clk = ~clk;

  nmru_read_cache u_nmru_read_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_hit(resp_hit), .resp_err(resp_err),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] + 8'(a[15:8] * 3) + 8'h11;
  endfunction

  function automatic logic [63:0] blk(input logic [15:0] base);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[i*8 +: 8] = mb(base + 16'(i));
    return d;
  endfunction

  function automatic logic [31:0] expd(input logic [15:0] a, input logic [1:0] sz);
    logic [31:0] d = '0;
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int i = 0; i < n; i++) d[i*8 +: 8] = mb(a + 16'(i));
    return d;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers three cycles after a request appears
  initial begin
    int lat = 3;
    forever begin
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (mem_req_valid) begin
        if (mem_req_valid && req_ready) busy_bad = 1'b1;
        if (lat == 0) begin
          mem_resp_valid = 1'b1;
          mem_resp_data  = blk(mem_req_addr);
          last_fetch     = mem_req_addr;
          fetches++;
          lat = 3;
        end else lat--;
      end
    end
  end

  task automatic do_read(input logic [15:0] a, input logic [1:0] sz,
                         input logic exp_err, input logic exp_fetch, input string req);
    int f0 = fetches;
    int n = 0;
    logic [31:0] ed;
    busy_bad = 1'b0;
    @(negedge clk);
    chk(req_ready, {req, " ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    ed = exp_err ? 32'd0 : expd(a, sz);
    chk(resp_valid, {req, " response"}, 32'(resp_valid), 32'd1);
    chk(resp_err == exp_err, {req, " error flag"}, 32'(resp_err), 32'(exp_err));
    chk(resp_hit == (!exp_err && !exp_fetch), {req, " hit flag"}, 32'(resp_hit), 32'(!exp_err && !exp_fetch));
    chk(resp_data == ed, {req, " data"}, resp_data, ed);
    chk((fetches - f0) == int'(exp_fetch), {req, " fetch count"}, 32'(fetches - f0), 32'(exp_fetch));
    if (exp_fetch) begin
      chk(last_fetch == {a[15:3], 3'b000}, "R4 fetch address", 32'(last_fetch), 32'({a[15:3], 3'b000}));
      chk(!busy_bad, "R8 ready low during refill", 32'(busy_bad), 32'd0);
    end else begin
      chk(n == 0, {req, " one-cycle latency"}, 32'(n), 32'd0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R1 no fetch after reset", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_cold_miss;
    do_read(16'h0104, 2'd2, 1'b0, 1'b1, "R1 cold miss");
    do_read(16'h0104, 2'd2, 1'b0, 1'b0, "R5 reread after fill");
  endtask

  task automatic t_hits;
    do_read(16'h0102, 2'd1, 1'b0, 1'b0, "R3 halfword hit");
    do_read(16'h0107, 2'd0, 1'b0, 1'b0, "R3 byte hit");
    do_read(16'h0100, 2'd2, 1'b0, 1'b0, "R3 word hit");
  endtask

  task automatic t_invalid_first;
    do_read(16'h0200, 2'd2, 1'b0, 1'b1, "R6 second tag fill");
    do_read(16'h0104, 2'd2, 1'b0, 1'b0, "R6 first tag kept");
    do_read(16'h0204, 2'd2, 1'b0, 1'b0, "R6 second tag hit");
  endtask

  task automatic t_nmru;
    do_read(16'h0100, 2'd2, 1'b0, 1'b0, "R7 touch way0");
    do_read(16'h0300, 2'd2, 1'b0, 1'b1, "R2 conflicting tag miss");
    do_read(16'h0100, 2'd2, 1'b0, 1'b0, "R7 recently used line kept");
    do_read(16'h0200, 2'd2, 1'b0, 1'b1, "R7 evicted line misses");
    do_read(16'h0100, 2'd2, 1'b0, 1'b0, "R7 line still resident");
    do_read(16'h0300, 2'd2, 1'b0, 1'b1, "R7 other victim chosen");
  endtask

  task automatic t_sets;
    do_read(16'h0008, 2'd1, 1'b0, 1'b1, "R10 set1 fill");
    do_read(16'h0010, 2'd1, 1'b0, 1'b1, "R10 set2 fill");
    do_read(16'h0018, 2'd1, 1'b0, 1'b1, "R10 set3 fill");
    do_read(16'h000C, 2'd2, 1'b0, 1'b0, "R10 set1 hit");
    do_read(16'h0106, 2'd1, 1'b0, 1'b0, "R10 set0 untouched");
  endtask

  task automatic t_misalign;
    do_read(16'h0102, 2'd2, 1'b1, 1'b0, "R9 word misaligned");
    do_read(16'h0101, 2'd1, 1'b1, 1'b0, "R9 halfword misaligned");
    do_read(16'h0100, 2'd3, 1'b1, 1'b0, "R9 illegal size");
    do_read(16'h0405, 2'd1, 1'b1, 1'b0, "R9 misaligned miss");
    do_read(16'h0105, 2'd0, 1'b0, 1'b0, "R9 byte any offset");
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_miss();
    t_hits();
    t_invalid_first();
    t_nmru();
    t_sets();
    t_misalign();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule